// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is a single 32-bit timer channel. Its count rate comes from one of three sources: the system clock used directly, the system clock divided by sixteen, or rising edges on an external clock pin. The chosen rate then passes through an 8-bit prescaler before it reaches the counter. The counter can run freely. It can also return to zero each time it equals a reference value, which makes it a periodic timer.

Two event sources share the channel. A capture pin, synchronised inside the block, copies the counter into a capture register on a selectable edge. A compare match against the reference drives the timer output pin, which either toggles or gives a pulse one prescaled tick long. Each event sets a flag. Each flag can raise an interrupt request, a DMA request, or both, under separate enables. Software clears a flag by writing a one to it.

Software reaches the channel through a simple word-wide register port. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `cap_cmp_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `tmr_out` and all four request outputs are low.
- R2: Control bits [2:1] choose the count source. 0 is every clock, 1 is one clock in sixteen, 2 is each rising edge of `ext_clk_pin` after a two-flop synchroniser, and 3 stops counting.
- R3: Control bits [23:16] hold a prescale value P. The counter advances once per P+1 source events, and holds its value between those ticks.
- R4: While control bit 0 (run) is clear, the counter, the prescaler and the divide-by-16 stage are held at zero, and no capture or compare event occurs.
- R5: With control bit 3 (restart) clear, each prescaled tick adds one to the counter, wrapping modulo 2^32.
- R6: With restart set, a tick that finds the counter equal to the reference loads zero, so the count runs from 0 to the reference value and starts again.
- R7: Control bits [5:4] choose the capture edge: 0 none, 1 rising, 2 falling, 3 both. `cap_pin` passes through two flops. A chosen edge copies the counter into the capture register and sets status bit 0, on the third rising clock edge after the pin changes.
- R8: A prescaled tick that finds the counter equal to the reference is a compare match, and it sets status bit 1.
- R9: With control bit 6 clear (pulse mode), a match drives `tmr_out` high. The output falls on the next tick that is not a match, or when run is cleared.
- R10: With control bit 6 set (toggle mode), each match inverts `tmr_out`.
- R11: Writing a 1 to a status bit clears it. Writing 0 has no effect. An event in the same cycle as the clear leaves the bit set.
- R12: Each request output is its flag ANDed with its own enable: `cap_irq` uses control bit 7, `cap_dma` bit 8, `cmp_irq` bit 9 and `cmp_dma` bit 10.
- R13: Register addresses are: 0 control (reads back only bits [10:0] and [23:16]), 1 reference, 2 capture (read-only), 3 counter (read-only), 4 status. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cap_pin | input | 1 | Asynchronous capture input |
| ext_clk_pin | input | 1 | Asynchronous external count source |
| tmr_out | output | 1 | Compare output pin |
| cap_irq | output | 1 | Capture interrupt request |
| cap_dma | output | 1 | Capture DMA request |
| cmp_irq | output | 1 | Compare interrupt request |
| cmp_dma | output | 1 | Compare DMA request |

## Verification
The hardest case to reach from the ports is a capture event that lands in the very cycle in which software writes a one to clear the capture flag. The event comes out of a three-flop pipeline behind an asynchronous pin, so it cannot be timed directly from the bus. The stimulus raises `cap_pin` just after one falling clock edge and waits one more falling edge. It then issues the status write, whose strobe is sampled on the same rising edge at which the synchronised edge is acted on. The flag must stay set. A following write with no event must then clear it.

// File: rtl/cct_pkg.sv
// Shared types for the capture/compare timer channel.
// Assumes the control field layout below is the software-visible one.
package cct_pkg;

    typedef enum logic [1:0] {
        SRC_SYS_DIV1  = 2'd0,
        SRC_SYS_DIV16 = 2'd1,
        SRC_EXT_PIN   = 2'd2,
        SRC_HALT      = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } cap_edge_e;

    // Packed LSB-first: run is bit 0, cmp_dma_en is bit 10.
    typedef struct packed {
        logic      cmp_dma_en;
        logic      cmp_irq_en;
        logic      cap_dma_en;
        logic      cap_irq_en;
        logic      toggle_mode;
        cap_edge_e edge_sel;
        logic      restart;
        clk_src_e  src;
        logic      run;
    } ctrl_t;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_REF   = 3'd1;
    localparam logic [2:0] A_CAPT  = 3'd2;
    localparam logic [2:0] A_COUNT = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;
    localparam int         PRE_LSB = 16;

endpackage

// File: rtl/cct_sync.sv
// Multi-bit synchroniser with edge detection.
// Each bit runs through STAGES flops, plus one more flop that holds the
// previous synchronised level. Assumes each input level lasts at least two clocks.
module cct_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [STAGES:0][W-1:0] pipe_q;

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], din};
    end

    // Compare the synchronised level with the level one clock older.
    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/cct_tick.sv
// Count-enable generator: selects the source and applies the prescaler.
// Produces a single-cycle tick; every register runs on the system clock.
// Assumes SYS_DIV is a power of two of at least 2.
module cct_tick import cct_pkg::*; #(
    parameter int PRE_W   = 8,
    parameter int SYS_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  clk_src_e         src,
    input  logic [PRE_W-1:0] presc,
    input  logic             ext_rise,
    output logic             tick
);
    localparam int DIV_W = $clog2(SYS_DIV);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYS_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [PRE_W-1:0] ps_q;
    logic             base;
    logic             ps_done;

    // Fixed system-clock divider, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    // Pick one source event per cycle.
    always_comb begin
        unique case (src)
            SRC_SYS_DIV1:  base = 1'b1;
            SRC_SYS_DIV16: base = (div_q == DIV_LAST);
            SRC_EXT_PIN:   base = ext_rise;
            SRC_HALT:      base = 1'b0;
        endcase
    end

    // >= keeps the prescaler from stalling after presc shrinks mid-count.
    assign ps_done = (ps_q >= presc);

    // Prescaler counts source events and wraps after presc+1 of them.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) ps_q <= '0;
        else if (base)      ps_q <= ps_done ? '0 : ps_q + 1'b1;
    end

    assign tick = run & base & ps_done;
endmodule

// File: rtl/cct_core.sv
// Counter, capture register and compare output for one channel.
// Advances only on tick; capture edges arrive already synchronised.
module cct_core import cct_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic             toggle_mode,
    input  cap_edge_e        edge_sel,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             cap_rise,
    input  logic             cap_fall,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture,
    output logic             hit,
    output logic             cap_event,
    output logic             tmr_out
);
    logic edge_ok;

    assign hit = tick & (count == ref_val);

    // Qualify the synchronised edges against the selected capture edge.
    always_comb begin
        unique case (edge_sel)
            EDGE_OFF:  edge_ok = 1'b0;
            EDGE_RISE: edge_ok = cap_rise;
            EDGE_FALL: edge_ok = cap_fall;
            EDGE_BOTH: edge_ok = cap_rise | cap_fall;
        endcase
    end
    assign cap_event = run & edge_ok;

    // Main counter: cleared when stopped, restarts on match when asked.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)       count <= '0;
        else if (hit && restart)  count <= '0;
        else if (tick)            count <= count + 1'b1;
    end

    // Latch the counter on a qualified capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         capture <= '0;
        else if (cap_event) capture <= count;
    end

    // Output pin action: toggle on match, or a one-tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                tmr_out <= 1'b0;
        else if (toggle_mode)      tmr_out <= hit ? ~tmr_out : tmr_out;
        else if (hit)              tmr_out <= 1'b1;
        else if (tick || !run)     tmr_out <= 1'b0;
    end
endmodule

// File: rtl/cap_cmp_timer.sv
// Top of the capture/compare timer channel: register port, event flags
// and request outputs. Assumes a single clock domain, and asynchronous pins
// that each hold a level for at least two clocks.
module cap_cmp_timer import cct_pkg::*; #(
    parameter int CNT_W       = 32,
    parameter int PRE_W       = 8,
    parameter int SYS_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             cap_pin,
    input  logic             ext_clk_pin,
    output logic             tmr_out,
    output logic             cap_irq,
    output logic             cap_dma,
    output logic             cmp_irq,
    output logic             cmp_dma
);
    localparam int CTRL_BITS = $bits(ctrl_t);

    ctrl_t            ctl_q;
    logic [PRE_W-1:0] presc_q;
    logic [CNT_W-1:0] ref_q;
    logic             cap_flag, cmp_flag;
    logic [1:0]       w1c;
    logic [1:0]       pin_rise, pin_fall;
    logic             tick, hit, cap_event;
    logic [CNT_W-1:0] count, capture;
    logic             ctl_run, ctl_restart, ctl_toggle;

    assign ctl_run     = ctl_q.run;
    assign ctl_restart = ctl_q.restart;
    assign ctl_toggle  = ctl_q.toggle_mode;

    // Software-writable configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            presc_q <= '0;
            ref_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) begin
                ctl_q   <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
                presc_q <= bus_wdata[PRE_LSB +: PRE_W];
            end
            if (bus_addr == A_REF) ref_q <= bus_wdata;
        end
    end

    assign w1c = (bus_wr && bus_addr == A_STAT) ? bus_wdata[1:0] : 2'b00;

    // Event flags: set by hardware, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            cap_flag <= cap_event | (cap_flag & ~w1c[0]);
            cmp_flag <= hit       | (cmp_flag & ~w1c[1]);
        end
    end

    assign cap_irq = cap_flag & ctl_q.cap_irq_en;
    assign cap_dma = cap_flag & ctl_q.cap_dma_en;
    assign cmp_irq = cmp_flag & ctl_q.cmp_irq_en;
    assign cmp_dma = cmp_flag & ctl_q.cmp_dma_en;

    // Combinational register read.
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = CNT_W'({presc_q, {(PRE_LSB-CTRL_BITS){1'b0}}, ctl_q});
            A_REF:   bus_rdata = ref_q;
            A_CAPT:  bus_rdata = capture;
            A_COUNT: bus_rdata = count;
            A_STAT:  bus_rdata = CNT_W'({cmp_flag, cap_flag});
            default: bus_rdata = '0;
        endcase
    end

    cct_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_clk_pin, cap_pin}),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    cct_tick #(.PRE_W(PRE_W), .SYS_DIV(SYS_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_run),
        .src     (ctl_q.src),
        .presc   (presc_q),
        .ext_rise(pin_rise[1]),
        .tick    (tick)
    );

    cct_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctl_run),
        .tick       (tick),
        .restart    (ctl_restart),
        .toggle_mode(ctl_toggle),
        .edge_sel   (ctl_q.edge_sel),
        .ref_val    (ref_q),
        .cap_rise   (pin_rise[0]),
        .cap_fall   (pin_fall[0]),
        .count      (count),
        .capture    (capture),
        .hit        (hit),
        .cap_event  (cap_event),
        .tmr_out    (tmr_out)
    );
endmodule

// File: rtl/cct_checker.sv
// Temporal properties of the timer channel, bound onto the top module.
module cct_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             restart,
    input logic             toggle_mode,
    input logic             tick,
    input logic             hit,
    input logic [CNT_W-1:0] count,
    input logic             cmp_flag,
    input logic             tmr_out
);
    assert_stopped_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == '0);

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(count));

    assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(hit && restart)) |=> count == $past(count) + 1'b1);

    assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && restart) |=> count == '0);

    assert_flag_from_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> $past(hit));

    assert_pulse_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_out && !toggle_mode && tick && !hit) |=> !tmr_out);

    assert_toggle_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && toggle_mode) |=> tmr_out != $past(tmr_out));
endmodule

bind cap_cmp_timer cct_checker #(.CNT_W(CNT_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctl_run),
    .restart    (ctl_restart),
    .toggle_mode(ctl_toggle),
    .tick       (tick),
    .hit        (hit),
    .count      (count),
    .cmp_flag   (cmp_flag),
    .tmr_out    (tmr_out)
);

// File: tb/sim_cap_cmp_timer.sv
// Bench: a behavioural reference model is compared against the design at every falling edge.
module sim_cap_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd3;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_pin = 1'b0;
    logic        ext_clk_pin = 1'b0;
    logic        tmr_out, cap_irq, cap_dma, cmp_irq, cmp_dma;

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    cap_cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
        .ext_clk_pin(ext_clk_pin), .tmr_out(tmr_out), .cap_irq(cap_irq),
        .cap_dma(cap_dma), .cmp_irq(cmp_irq), .cmp_dma(cmp_dma)
    );

    // ---------------- reference model ----------------
    bit [31:0] m_ctrl, m_ref, m_cnt, m_cap;
    int        m_div, m_ps;
    bit        m_out, m_capf, m_cmpf;
    bit        cq[$] = '{0, 0, 0};
    bit        eq[$] = '{0, 0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_ref = 0; m_cnt = 0; m_cap = 0;
            m_div = 0; m_ps = 0; m_out = 0; m_capf = 0; m_cmpf = 0;
            cq = '{0, 0, 0}; eq = '{0, 0, 0};
        end else begin
            bit run, base, tick, hit, cr, cf, capev, tog;
            int src, psv, em;
            bit [1:0] clr;
            run = m_ctrl[0]; src = int'(m_ctrl[2:1]); psv = int'(m_ctrl[23:16]);
            em = int'(m_ctrl[5:4]); tog = m_ctrl[6];
            case (src)
                0: base = 1;
                1: base = (m_div == 15);
                2: base = eq[1] && !eq[2];
                default: base = 0;
            endcase
            tick = run && base && (m_ps >= psv);
            hit  = tick && (m_cnt == m_ref);
            cr = cq[1] && !cq[2];
            cf = !cq[1] && cq[2];
            capev = run && ((em == 1 && cr) || (em == 2 && cf) || (em == 3 && (cr || cf)));
            clr = (bus_wr && bus_addr == 3'd4) ? bus_wdata[1:0] : 2'b00;
            if (capev) m_cap = m_cnt;
            if (tog) begin
                if (hit) m_out = !m_out;
            end else if (hit) m_out = 1;
            else if (tick || !run) m_out = 0;
            if (!run) m_cnt = 0;
            else if (hit && m_ctrl[3]) m_cnt = 0;
            else if (tick) m_cnt = m_cnt + 1;
            m_div = run ? (m_div + 1) % 16 : 0;
            if (!run) m_ps = 0;
            else if (base) m_ps = (m_ps >= psv) ? 0 : m_ps + 1;
            m_capf = capev || (m_capf && !clr[0]);
            m_cmpf = hit || (m_cmpf && !clr[1]);
            if (bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata & 32'h00FF07FF;
            if (bus_wr && bus_addr == 3'd1) m_ref = bus_wdata;
            cq.push_front(cap_pin); void'(cq.pop_back());
            eq.push_front(ext_clk_pin); void'(eq.pop_back());
        end
    end

    function automatic bit [31:0] m_rdata(input bit [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_ref;
            3'd2: return m_cap;
            3'd3: return m_cnt;
            3'd4: return {30'd0, m_cmpf, m_capf};
            default: return 0;
        endcase
    endfunction

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            logic [4:0] got, exp;
            got = {tmr_out, cap_irq, cap_dma, cmp_irq, cmp_dma};
            exp = {m_out, m_capf & m_ctrl[7], m_capf & m_ctrl[8], m_cmpf & m_ctrl[9], m_cmpf & m_ctrl[10]};
            checks++;
            if (got !== exp || bus_rdata !== m_rdata(bus_addr)) begin
                errors++;
                $display("FAIL %s model: pins %b exp %b, rdata[%0d] %h exp %h",
                         phase, got, exp, bus_addr, bus_rdata, m_rdata(bus_addr));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        @(negedge clk); #1 bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1 bus_wr = 0; bus_addr = 3'd3;
    endtask

    task automatic rd(input bit [2:0] a, output logic [31:0] v);
        @(negedge clk); #1 bus_addr = a;
        @(negedge clk); v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic measure(input int k, output logic [31:0] d);
        logic [31:0] a;
        @(negedge clk); #1 bus_addr = 3'd3;
        @(negedge clk); a = bus_rdata;
        repeat (k) @(negedge clk);
        d = bus_rdata - a;
    endtask

    task automatic cap_set(input bit v);
        @(negedge clk); #1 cap_pin = v;
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v, v2;
        int hi, mx;
        repeat (3) @(posedge clk);
        chk_on = 1;
        @(negedge clk); #1 rst_n = 1;

        phase = "R1";
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset pins", {27'd0, tmr_out, cap_irq, cap_dma, cmp_irq, cmp_dma}, 32'h0);

        phase = "R13";
        wr(3'd1, 32'h0000_1234);
        rd(3'd1, v); check("R13 reference readback", v, 32'h0000_1234);
        wr(3'd0, 32'hFFFF_FFFE);
        rd(3'd0, v); check("R13 control mask", v, 32'h00FF_07FE);
        rd(3'd6, v); check("R13 unused address", v, 32'h0);
        wr(3'd0, 32'h0);

        phase = "R5";
        wr(3'd0, 32'h1);
        idle(3);
        measure(10, v); check("R5 one per clock", v, 32'd10);

        phase = "R3";
        wr(3'd0, 32'h0003_0001);
        measure(40, v); check("R3 prescale by 4", v, 32'd10);

        phase = "R2";
        wr(3'd0, 32'h0000_0003);
        measure(64, v); check("R2 divide by 16", v, 32'd4);
        wr(3'd0, 32'h0000_0007);
        measure(10, v); check("R2 halted source", v, 32'd0);
        wr(3'd0, 32'h0000_0005);
        idle(2);
        rd(3'd3, v);
        for (int i = 0; i < 8; i++) begin
            ext_clk_pin = 1; idle(2);
            ext_clk_pin = 0; idle(2);
        end
        idle(4);
        rd(3'd3, v2); check("R2 external edges", v2 - v, 32'd8);

        phase = "R4";
        wr(3'd0, 32'h0);
        rd(3'd3, v); check("R4 stopped clears count", v, 32'h0);
        check("R4 output low when stopped", {31'd0, tmr_out}, 32'h0);

        phase = "R6";
        wr(3'd4, 32'h3);
        wr(3'd1, 32'd5);
        wr(3'd0, 32'h0001_0609);
        idle(20);
        mx = 0;
        @(negedge clk); #1 bus_addr = 3'd3;
        hi = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (int'(bus_rdata) > mx) mx = int'(bus_rdata);
            if (tmr_out) hi++;
        end
        check("R6 count peaks at reference", mx, 32'd5);
        phase = "R9";
        check("R9 pulse high two cycles per period", hi, 32'd4);
        phase = "R8";
        check("R8 compare requests", {30'd0, cmp_irq, cmp_dma}, 32'h3);

        phase = "R10";
        wr(3'd0, 32'h0000_0649);
        idle(20);
        hi = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (tmr_out) hi++;
        end
        check("R10 toggle half duty", hi, 32'd12);

        phase = "R11";
        wr(3'd0, 32'h0000_0600);
        check("R11 flag kept while stopped", {31'd0, cmp_irq}, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R11 writing other bit keeps flag", v, 32'h2);
        wr(3'd4, 32'h2);
        rd(3'd4, v); check("R11 write one clears", v, 32'h0);

        phase = "R7";
        wr(3'd0, 32'h0000_0191);
        cap_set(1); idle(5);
        check("R7 rising capture", {30'd0, cap_irq, cap_dma}, 32'h3);
        wr(3'd4, 32'h1);
        cap_set(0); idle(5);
        check("R7 rising mode ignores fall", {31'd0, cap_irq}, 32'h0);
        wr(3'd0, 32'h0000_01A1);
        cap_set(1); idle(5);
        check("R7 falling mode ignores rise", {31'd0, cap_irq}, 32'h0);
        cap_set(0); idle(5);
        check("R7 falling capture", {31'd0, cap_irq}, 32'h1);
        wr(3'd4, 32'h1);
        wr(3'd0, 32'h0000_0181);
        rd(3'd2, v);
        cap_set(1); idle(5); cap_set(0); idle(5);
        rd(3'd2, v2); check("R7 edge off keeps capture", v2, v);
        check("R7 edge off no flag", {31'd0, cap_irq}, 32'h0);
        wr(3'd0, 32'h0000_01B1);
        cap_set(1); idle(5);
        check("R7 any edge rise", {31'd0, cap_irq}, 32'h1);
        wr(3'd4, 32'h1);
        cap_set(0); idle(5);
        check("R7 any edge fall", {31'd0, cap_irq}, 32'h1);

        phase = "R12";
        wr(3'd4, 32'h1);
        wr(3'd0, 32'h0000_00B1);
        cap_set(1); idle(5);
        check("R12 irq only", {30'd0, cap_irq, cap_dma}, 32'h2);
        wr(3'd4, 32'h1);
        wr(3'd0, 32'h0000_0131);
        cap_set(0); idle(5);
        check("R12 dma only", {30'd0, cap_irq, cap_dma}, 32'h1);

        phase = "R11";
        wr(3'd0, 32'h0000_01B1);
        wr(3'd4, 32'h1);
        cap_set(1);
        @(negedge clk); #1;
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R11 set beats clear", v & 32'h1, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R11 later clear works", v & 32'h1, 32'h0);

        idle(4);
        finish_run();
    end
endmodule